// File: doc/BRIEF.md
# Edge-Triggered Heartbeat Watchdog

This block supervises a processor by watching a heartbeat line that software toggles while it runs. Any change of level, rising or falling, restarts a fixed countdown. If the countdown runs out before the next change, the active-low watchdog flag goes low. It stays low until new heartbeat activity clears the timer. The timeout is given in clock cycles as a parameter. Silicon sets it to match a period of roughly one to two seconds, and simulation uses a short value.

The timer is disabled, meaning cleared and not counting, in two cases: while the system reset flag is active, and while the heartbeat is marked as floating. Once disabled, it waits for a fresh heartbeat transition before it starts counting again. A bad supply forces the flag low at once, without touching the timer. When the supply recovers, the flag returns high in the same cycle, with no minimum low time.

Top module: `heartbeat_watchdog`

## Requirements
- R1: While `rstN` is low, `wdoN` is high (with `supplyOk` high) and the timer is cleared.
- R2: After a heartbeat level change is first sampled on a rising clock edge k, `wdoN` stays high through edge k+TIMEOUT_CYCLES+1. The input path is a two-flop synchronizer followed by one delay flop.
- R3: When no transition arrives, `wdoN` goes low on edge k+TIMEOUT_CYCLES+2.
- R4: Once low, `wdoN` stays low without wrap-around until a heartbeat transition, system reset or floating flag clears the timer. The internal count never exceeds TIMEOUT_CYCLES-1.
- R5: Both a rising and a falling transition clear an expired flag, and both restart a running countdown from zero.
- R6: After `rstN` releases with the heartbeat low, the timer does not count until the first transition is seen.
- R7: A heartbeat pulse lasting a single clock period is recognized as activity and restarts the countdown.
- R8: While `sysResetActive` is high, the timer is held cleared. Afterwards, counting resumes only on a new transition.
- R9: While `hbFloat` is high, the timer is held cleared. Afterwards, counting resumes only on a new transition.
- R10: While `supplyOk` is low, `wdoN` is low. When `supplyOk` returns high with the timer not expired, `wdoN` is high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset of the block's flops |
| heartbeat | input | 1 | Asynchronous processor heartbeat line |
| hbFloat | input | 1 | High when the heartbeat line is three-stated |
| sysResetActive | input | 1 | High while the system reset is asserted |
| supplyOk | input | 1 | High while the supply is above its threshold |
| wdoN | output | 1 | Active-low watchdog timeout flag |

## Verification
The countdown is run with rising edges, falling edges and a single-cycle pulse. This shows that both polarities and a minimal-width pulse each restart it. Runs with no activity are sampled one cycle before and one cycle after the expected expiry, which catches off-by-one errors in the sync latency or the terminal count. A long idle run after expiry shows that the flag does not wrap around. The floating flag and the system reset are each applied, then released without activity, to show that the timer is cleared and stays disarmed until a new transition arrives. The supply flag is dropped while the timer is not expired, to show that it forces the output low and lets it recover at once.

// File: rtl/wd_pkg.sv
package wd_pkg;
  typedef struct packed {
    logic clear;  // zero the counter and drop the expired flag
    logic count;  // advance the counter by one
  } wdStrobes_t;
endpackage

// File: rtl/wd_ctrl.sv
module wd_ctrl
  import wd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       heartbeat,
  input  logic       hbFloat,
  input  logic       sysResetActive,
  output wdStrobes_t strobes
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   delayQ;
  logic                   armedQ;
  logic                   hbEdge;
  logic                   disable_;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncQ[i] <= 1'b0;
          else       syncQ[i] <= heartbeat;
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncQ[i] <= 1'b0;
          else       syncQ[i] <= syncQ[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) delayQ <= 1'b0;
    else       delayQ <= syncQ[SYNC_STAGES-1];

  assign hbEdge   = syncQ[SYNC_STAGES-1] ^ delayQ;
  assign disable_ = sysResetActive | hbFloat;

  // Armed only after a transition seen while enabled.
  always_ff @(posedge clk or negedge rstN)
    if (!rstN)         armedQ <= 1'b0;
    else if (disable_) armedQ <= 1'b0;
    else if (hbEdge)   armedQ <= 1'b1;

  always_comb begin
    strobes.clear = disable_ | hbEdge;
    strobes.count = armedQ & ~strobes.clear;
  end
endmodule

// File: rtl/wd_datapath.sv
module wd_datapath
  import wd_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 1000,
  localparam int CW = (TIMEOUT_CYCLES > 1) ? $clog2(TIMEOUT_CYCLES) : 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  wdStrobes_t strobes,
  output logic       expired,
  output logic [CW-1:0] cntOut
);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYCLES - 1);

  logic [CW-1:0] cntQ;
  logic          expQ;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      cntQ <= '0;
      expQ <= 1'b0;
    end else if (strobes.clear) begin
      cntQ <= '0;
      expQ <= 1'b0;
    end else if (strobes.count && !expQ) begin
      if (cntQ == LAST) expQ <= 1'b1;
      else              cntQ <= cntQ + 1'b1;
    end

  assign expired = expQ;
  assign cntOut  = cntQ;
endmodule

// File: rtl/heartbeat_watchdog.sv
module heartbeat_watchdog #(
  parameter int TIMEOUT_CYCLES = 160_000_000,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic heartbeat,
  input  logic hbFloat,
  input  logic sysResetActive,
  input  logic supplyOk,
  output logic wdoN
);
  localparam int CW = (TIMEOUT_CYCLES > 1) ? $clog2(TIMEOUT_CYCLES) : 1;

  wd_pkg::wdStrobes_t strobes;
  logic               expired;
  logic [CW-1:0]      cnt;

  wd_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .heartbeat(heartbeat), .hbFloat(hbFloat),
    .sysResetActive(sysResetActive), .strobes(strobes)
  );

  wd_datapath #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .expired(expired), .cntOut(cnt)
  );

  // Supply loss overrides directly, no pulse stretching.
  assign wdoN = supplyOk & ~expired;
endmodule

// File: rtl/heartbeat_watchdog_chk.sv
module heartbeat_watchdog_chk #(
  parameter int TIMEOUT_CYCLES = 160_000_000,
  parameter int CW = 1
) (
  input logic          clk,
  input logic          rstN,
  input logic          hbFloat,
  input logic          sysResetActive,
  input logic          supplyOk,
  input logic          wdoN,
  input logic          expired,
  input logic          clearStb,
  input logic          countStb,
  input logic [CW-1:0] cnt
);
  assert_sysreset_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    sysResetActive |=> !expired);

  assert_float_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    hbFloat |=> !expired);

  assert_supply_forces_low_R10: assert property (@(posedge clk) disable iff (!rstN)
    !supplyOk |-> !wdoN);

  assert_expiry_needs_count_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(expired) |-> $past(countStb));

  assert_hold_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    (expired && !clearStb) |=> expired);

  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CW'(TIMEOUT_CYCLES - 1));
endmodule

bind heartbeat_watchdog heartbeat_watchdog_chk #(
  .TIMEOUT_CYCLES(TIMEOUT_CYCLES), .CW(CW)
) u_chk (
  .clk(clk), .rstN(rstN), .hbFloat(hbFloat), .sysResetActive(sysResetActive),
  .supplyOk(supplyOk), .wdoN(wdoN), .expired(expired),
  .clearStb(strobes.clear), .countStb(strobes.count), .cnt(cnt)
);

// File: tb/tb_heartbeat_watchdog.sv
module tb_heartbeat_watchdog;
  localparam int T = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic heartbeat = 1'b0;
  logic hbFloat = 1'b0;
  logic sysResetActive = 1'b0;
  logic supplyOk = 1'b1;
  logic wdoN;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  heartbeat_watchdog #(.TIMEOUT_CYCLES(T)) dut (
    .clk(clk), .rstN(rstN), .heartbeat(heartbeat), .hbFloat(hbFloat),
    .sysResetActive(sysResetActive), .supplyOk(supplyOk), .wdoN(wdoN)
  );

  typedef struct packed {
    logic       tog;
    logic       flt;
    logic       srst;
    logic       sup;
    logic [7:0] ticks;
    logic       exp;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,1'b0,1'b1, 8'd30,    1'b1, 8'd6},   // R6 idle after reset, unarmed
    '{1'b1,1'b0,1'b0,1'b1, 8'(T+2),  1'b1, 8'd2},   // R2 rising edge, last high edge
    '{1'b0,1'b0,1'b0,1'b1, 8'd1,     1'b0, 8'd3},   // R3 expiry edge
    '{1'b0,1'b0,1'b0,1'b1, 8'd30,    1'b0, 8'd4},   // R4 stays low, no wrap
    '{1'b1,1'b0,1'b0,1'b1, 8'd3,     1'b1, 8'd5},   // R5 falling edge clears
    '{1'b0,1'b0,1'b0,1'b1, 8'd10,    1'b1, 8'd5},   // R5 counting, count 10
    '{1'b1,1'b0,1'b0,1'b1, 8'd12,    1'b1, 8'd5},   // R5 restart mid-count
    '{1'b0,1'b0,1'b0,1'b1, 8'd20,    1'b0, 8'd3},   // R3 expires after restart
    '{1'b1,1'b0,1'b0,1'b1, 8'd3,     1'b1, 8'd5},   // R5 clear again
    '{1'b0,1'b0,1'b0,1'b0, 8'd1,     1'b0, 8'd10},  // R10 supply bad forces low
    '{1'b0,1'b0,1'b0,1'b1, 8'd1,     1'b1, 8'd10},  // R10 immediate recovery
    '{1'b0,1'b1,1'b0,1'b1, 8'd30,    1'b1, 8'd9},   // R9 floating holds cleared
    '{1'b0,1'b0,1'b0,1'b1, 8'd30,    1'b1, 8'd9},   // R9 stays disarmed after float
    '{1'b1,1'b0,1'b1,1'b1, 8'd30,    1'b1, 8'd8},   // R8 system reset holds cleared
    '{1'b0,1'b0,1'b0,1'b1, 8'd30,    1'b1, 8'd8},   // R8 disarmed after release
    '{1'b1,1'b0,1'b0,1'b1, 8'(T+2),  1'b1, 8'd8},   // R8 first transition rearms
    '{1'b0,1'b0,1'b0,1'b1, 8'd1,     1'b0, 8'd8}    // R8 expiry after rearm
  };

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic check(input logic exp, input int req, input string what);
    checks++;
    if (wdoN !== exp) begin
      failures++;
      $display("FAIL R%0d %s: wdoN=%b expected=%b", req, what, wdoN, exp);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired: bench hung");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) tick();
    check(1'b1, 1, "reset state");
    rstN = 1'b1;
    tick();
    check(1'b1, 1, "after reset release");

    for (int i = 0; i < NV; i++) begin
      hbFloat        = VECS[i].flt;
      sysResetActive = VECS[i].srst;
      supplyOk       = VECS[i].sup;
      if (VECS[i].tog) heartbeat = ~heartbeat;
      for (int j = 0; j < int'(VECS[i].ticks); j++) tick();
      check(VECS[i].exp, int'(VECS[i].req), $sformatf("vector %0d", i));
    end

    // R7: single-cycle pulse (heartbeat is low here after an even number of toggles)
    heartbeat = 1'b1;
    tick();
    heartbeat = 1'b0;
    for (int j = 0; j < T + 2; j++) tick();
    check(1'b1, 7, "one-cycle pulse restarts, last high edge");
    tick();
    check(1'b0, 7, "one-cycle pulse, expiry edge");

    // R10: supply drop while expired, then recovery stays low (expired)
    supplyOk = 1'b0;
    tick();
    check(1'b0, 10, "supply bad while expired");
    supplyOk = 1'b1;
    tick();
    check(1'b0, 4, "expired flag survives supply glitch");

    // R1: mid-run reset clears the flag
    rstN = 1'b0;
    tick();
    check(1'b1, 1, "asynchronous reset clears expired");
    rstN = 1'b1;
    tick();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule